// File: doc/BRIEF.md
# Dual-Processor Byte Mailbox

The block allows two processors to pass single bytes to each other through one shared port. The master processor uses a small synchronous register interface. It writes an outbound byte, reads the byte that came back from the slave, and reads a status word. The slave processor uses active-low read strobe, write strobe and chip select lines. All three are sampled on the block clock. A slave read enables the slave data bus and shows the outbound byte. A completed slave write stores the slave's data in an inbound capture register.

Each direction holds exactly one byte and has its own flag. The flag sets when a byte arrives and clears when the other side collects it. If a byte arrives while the flag is still set, the old byte is lost. This raises a sticky overrun bit. The master clears both overrun bits by writing to the status address. The master polls the status word to decide when to write or read.

Top module: `mbox_port`

## Requirements
- R1: After reset, the outbound and inbound registers are zero, all flags and overrun bits are zero, and `s_oe` is low.
- R2: A master write to address 0 loads `m_wdata` into the outbound register and sets the outbound-full flag from the next clock. A master read of address 0 returns the outbound register.
- R3: `s_oe` is high exactly while `s_rd_n` and `s_cs_n` are both low. `s_rdata` shows the outbound register while `s_oe` is high and is zero otherwise.
- R4: The outbound-full flag clears at the first clock edge where slave-read is active. Holding slave-read for more cycles clears nothing further.
- R5: A slave write is captured at the clock edge where `s_wr_n` is sampled high, having been low at the previous edge, while `s_cs_n` is low. At that edge `s_wdata` enters the inbound register and the inbound-full flag sets.
- R6: Write strobe pulses made while `s_cs_n` is high leave the inbound register and the inbound flags unchanged.
- R7: A master read of address 1 returns the inbound register in the same cycle. The inbound-full flag clears at the following edge.
- R8: A master read of address 2 returns the status word: bit 0 outbound-full, bit 1 inbound-full, bit 2 outbound-overrun, bit 3 inbound-overrun, all other bits zero. `m_rdata` is zero whenever `m_rd_en` is low.
- R9: A byte that arrives while its direction's flag is set overwrites the data and sets that direction's sticky overrun bit. If a take of the old byte happens in the same cycle, the flag stays set and no overrun is recorded.
- R10: A master write to address 2 clears both overrun bits. An overrun raised in the same cycle takes priority and stays set.
- R11: Address 3 reads as zero. Master writes to address 1 or 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_wr_en | input | 1 | Master write request |
| m_rd_en | input | 1 | Master read request |
| m_addr | input | 2 | Master register address |
| m_wdata | input | 8 | Master write data |
| m_rdata | output | 8 | Master read data |
| s_rd_n | input | 1 | Slave read strobe, active low |
| s_wr_n | input | 1 | Slave write strobe, active low |
| s_cs_n | input | 1 | Slave chip select, active low |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave read data, valid while s_oe is high |
| s_oe | output | 1 | Slave data bus output enable |

## Verification
Within one direction, a fill and a take can fall on the same clock edge. On the outbound side, a master write can coincide with the start of a slave read. On the inbound side, the finishing edge of a slave write can coincide with a master read of the inbound address. The bench lines up both pairs deliberately. It then checks that the flag stays set, that no overrun is recorded, and that the reader saw the old byte during the collision cycle. A third collision, an inbound overrun raised in the same cycle as a status clear, is also driven. The bench judges it by the overrun bit that remains afterward.

// File: rtl/mbox_pkg.sv
// Package: shared address map and status bit positions of the mailbox.
// Assumes a 2-bit master address and a status word of at least 4 bits.
package mbox_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        MB_ADDR_OUT  = 2'd0,
        MB_ADDR_IN   = 2'd1,
        MB_ADDR_STAT = 2'd2,
        MB_ADDR_RSV  = 2'd3
    } mb_addr_e;

    localparam int ST_OUT_FULL = 0;
    localparam int ST_IN_FULL  = 1;
    localparam int ST_OUT_OVR  = 2;
    localparam int ST_IN_OVR   = 3;
    localparam int ST_BITS     = 4;

endpackage

// File: rtl/mbox_strobe_decode.sv
// Module: decodes the slave's active-low strobes and chip select.
// It produces the bus output enable, a one-cycle pulse when a read begins,
// and a one-cycle pulse on the clock where a selected write strobe deasserts.
// Assumes the strobes have already been brought into the clk domain.
module mbox_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic s_rd_n,
    input  logic s_wr_n,
    input  logic s_cs_n,
    output logic rd_oe,
    output logic rd_start,
    output logic wr_done
);
    logic rd_q;
    logic wr_n_q;

    // Combinational read enable and edge pulses.
    always_comb begin
        rd_oe    = ~s_rd_n & ~s_cs_n;
        rd_start = rd_oe & ~rd_q;
        wr_done  = s_wr_n & ~wr_n_q & ~s_cs_n;
    end

    // Remember the previous read enable and write strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            wr_n_q <= 1'b1;
        end else begin
            rd_q   <= rd_oe;
            wr_n_q <= s_wr_n;
        end
    end
endmodule

// File: rtl/mbox_slot.sv
// Module: a one-byte mailbox slot with a full flag and a sticky overrun bit.
// A load stores data and sets full. A take clears full unless a load happens
// in the same cycle. A load while full, with no take, sets overrun. A clear
// request drops overrun, but a simultaneous set takes priority.
module mbox_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    input  logic              clr_ovr,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr
);
    logic ovr_set;

    // Overrun condition: a fill while the byte is still unread.
    always_comb ovr_set = load & full & ~take;

    // Data register: holds the last loaded byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (load) data <= load_data;
    end

    // Full flag: a fill sets it, a take clears it, and a fill wins.
    always_ff @(posedge clk) begin
        if (!rst_n) full <= 1'b0;
        else        full <= load | (full & ~take);
    end

    // Sticky overrun: a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (ovr_set) ovr <= 1'b1;
        else if (clr_ovr) ovr <= 1'b0;
    end
endmodule

// File: rtl/mbox_host_if.sv
// Module: master-side address decode and read multiplexer.
// Writes to the outbound or status address become strobes, and a read of
// the inbound address becomes a take. Read data is combinational and is zero
// while no read is requested or the address is reserved.
module mbox_host_if
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  m_wr_en,
    input  logic                  m_rd_en,
    input  logic [ADDR_W-1:0]     m_addr,
    input  logic [DATA_W-1:0]     out_data,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [DATA_W-1:0]     status,
    output logic                  out_load,
    output logic                  in_take,
    output logic                  ovr_clr,
    output logic [DATA_W-1:0]     m_rdata
);
    // Strobes decoded from the master access.
    always_comb begin
        out_load = m_wr_en & (m_addr == MB_ADDR_OUT);
        ovr_clr  = m_wr_en & (m_addr == MB_ADDR_STAT);
        in_take  = m_rd_en & (m_addr == MB_ADDR_IN);
    end

    // Read data multiplexer.
    always_comb begin
        m_rdata = '0;
        if (m_rd_en) begin
            case (m_addr)
                MB_ADDR_OUT:  m_rdata = out_data;
                MB_ADDR_IN:   m_rdata = in_data;
                MB_ADDR_STAT: m_rdata = status;
                default:      m_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbox_port.sv
// Module: top of the dual-processor byte mailbox.
// The outbound slot is filled by the master and emptied by a slave read.
// The inbound slot is filled by a slave write and emptied by a master read.
// Assumes all inputs are synchronous to clk.
module mbox_port
    import mbox_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_wr_en,
    input  logic              m_rd_en,
    input  logic [1:0]        m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic              s_cs_n,
    input  logic [DATA_W-1:0] s_wdata,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_oe
);
    localparam int PAD_W = DATA_W - ST_BITS;

    logic              rd_start, wr_done;
    logic              out_load, in_take, ovr_clr;
    logic [DATA_W-1:0] out_data, in_data, status;
    logic              out_full, in_full, out_ovr, in_ovr;

    mbox_strobe_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .s_cs_n(s_cs_n),
        .rd_oe(s_oe), .rd_start(rd_start), .wr_done(wr_done)
    );

    mbox_host_if #(.DATA_W(DATA_W)) u_host (
        .m_wr_en(m_wr_en), .m_rd_en(m_rd_en), .m_addr(m_addr),
        .out_data(out_data), .in_data(in_data), .status(status),
        .out_load(out_load), .in_take(in_take), .ovr_clr(ovr_clr),
        .m_rdata(m_rdata)
    );

    mbox_slot #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .load(out_load), .load_data(m_wdata), .take(rd_start),
        .clr_ovr(ovr_clr),
        .data(out_data), .full(out_full), .ovr(out_ovr)
    );

    mbox_slot #(.DATA_W(DATA_W)) u_in (
        .clk(clk), .rst_n(rst_n),
        .load(wr_done), .load_data(s_wdata), .take(in_take),
        .clr_ovr(ovr_clr),
        .data(in_data), .full(in_full), .ovr(in_ovr)
    );

    // Status word assembly and slave bus gating.
    always_comb begin
        status = {{PAD_W{1'b0}}, in_ovr, out_ovr, in_full, out_full};
        s_rdata = s_oe ? out_data : '0;
    end
endmodule

// File: rtl/mbox_port_checker.sv
// Module: temporal assertions for mbox_port, bound into every instance.
module mbox_port_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_wr_en,
    input logic              m_rd_en,
    input logic [1:0]        m_addr,
    input logic              s_rd_n,
    input logic              s_wr_n,
    input logic              s_cs_n,
    input logic [DATA_W-1:0] s_wdata,
    input logic [DATA_W-1:0] s_rdata,
    input logic              s_oe,
    input logic              out_full,
    input logic              in_full,
    input logic              out_ovr,
    input logic              in_ovr,
    input logic [DATA_W-1:0] in_data,
    input logic              wr_done
);
    assert_oe_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_oe |-> (!s_rd_n && !s_cs_n));

    assert_bus_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_oe |-> (s_rdata == '0));

    assert_out_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_en && m_addr == 2'd0) |=> out_full);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_oe) && !(m_wr_en && m_addr == 2'd0)) |=> !out_full);

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr_n && !$past(s_wr_n) && !s_cs_n) |=> (in_full && in_data == $past(s_wdata)));

    assert_no_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_cs_n |=> $stable(in_data));

    assert_take_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd_en && m_addr == 2'd1 && !wr_done) |=> !in_full);

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ovr && !(m_wr_en && m_addr == 2'd2)) |=> in_ovr);

    assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_en && m_addr == 2'd2) |=> !out_ovr);

    assert_in_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_en && m_addr == 2'd2 && !wr_done) |=> !in_ovr);
endmodule

bind mbox_port mbox_port_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .m_wr_en(m_wr_en), .m_rd_en(m_rd_en),
    .m_addr(m_addr), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .s_cs_n(s_cs_n),
    .s_wdata(s_wdata), .s_rdata(s_rdata), .s_oe(s_oe),
    .out_full(out_full), .in_full(in_full), .out_ovr(out_ovr),
    .in_ovr(in_ovr), .in_data(in_data), .wr_done(wr_done)
);

// File: tb/mbox_port_bench.sv
module mbox_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_wr_en = 1'b0, m_rd_en = 1'b0;
    logic [1:0] m_addr = 2'd0;
    logic [7:0] m_wdata = 8'h00, s_wdata = 8'h00;
    logic       s_rd_n = 1'b1, s_wr_n = 1'b1, s_cs_n = 1'b1;
    logic [7:0] m_rdata, s_rdata;
    logic       s_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbox_port u_mbox_port (
        .clk(clk), .rst_n(rst_n), .m_wr_en(m_wr_en), .m_rd_en(m_rd_en),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .s_cs_n(s_cs_n),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_oe(s_oe)
    );

    // Behavioural reference model.
    int  e_out, e_in;
    bit  e_of, e_if, e_oo, e_io, was_rd, prev_wr_high;

    always @(posedge clk) begin
        bit rd_now, rd_begin, wr_end, fill_o, fill_i, take_i, clr;
        if (!rst_n) begin
            e_out = 0; e_in = 0; e_of = 0; e_if = 0; e_oo = 0; e_io = 0;
            was_rd = 0; prev_wr_high = 1;
        end else begin
            rd_now   = (s_rd_n == 0) && (s_cs_n == 0);
            rd_begin = rd_now && !was_rd;
            wr_end   = (s_wr_n == 1) && !prev_wr_high && (s_cs_n == 0);
            fill_o   = m_wr_en && m_addr == 0;
            fill_i   = wr_end;
            take_i   = m_rd_en && m_addr == 1;
            clr      = m_wr_en && m_addr == 2;
            if (fill_o && e_of && !rd_begin) e_oo = 1;
            else if (clr) e_oo = 0;
            if (fill_i && e_if && !take_i) e_io = 1;
            else if (clr) e_io = 0;
            e_of = fill_o ? 1 : (rd_begin ? 0 : e_of);
            e_if = fill_i ? 1 : (take_i ? 0 : e_if);
            if (fill_o) e_out = m_wdata;
            if (fill_i) e_in = s_wdata;
            was_rd = rd_now;
            prev_wr_high = s_wr_n;
        end
    end

    function automatic int exp_mrd();
        if (!m_rd_en) return 0;
        case (m_addr)
            2'd0: return e_out;
            2'd1: return e_in;
            2'd2: return {e_io, e_oo, e_if, e_of};
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit oe_exp;
            oe_exp = (s_rd_n == 0) && (s_cs_n == 0);
            check("R3 s_oe", int'(s_oe), int'(oe_exp));
            check("R3 s_rdata", int'(s_rdata), oe_exp ? e_out : 0);
            check("R8 m_rdata", int'(m_rdata), exp_mrd());
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        m_wr_en = 0; m_rd_en = 0; s_rd_n = 1; s_wr_n = 1; s_cs_n = 1;
    endtask

    task automatic mwrite(int a, int d);
        cyc(); idle(); m_wr_en = 1; m_addr = 2'(a); m_wdata = 8'(d);
        cyc(); idle();
    endtask

    task automatic mread(int a, int exp, string tag);
        cyc(); idle(); m_rd_en = 1; m_addr = 2'(a);
        @(negedge clk); check(tag, int'(m_rdata), exp);
        cyc(); idle();
    endtask

    task automatic swrite(int d, bit cs_n);
        cyc(); idle(); s_cs_n = cs_n; s_wr_n = 0; s_wdata = 8'(d);
        cyc(); s_wr_n = 1;
        cyc(); idle();
    endtask

    task automatic sread(int exp, string tag);
        cyc(); idle(); s_cs_n = 0; s_rd_n = 0;
        @(negedge clk);
        check(tag, int'(s_oe), 1);
        check(tag, int'(s_rdata), exp);
        cyc(); cyc(); idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        mread(2, 8'h00, "R1 status");
        check("R1 s_oe", int'(s_oe), 0);
        mread(0, 8'h00, "R1 outbound");
        // R2 outbound load
        mwrite(0, 8'hA5);
        mread(0, 8'hA5, "R2 readback");
        mread(2, 8'h01, "R2 status");
        // R3 and R4 slave read
        sread(8'hA5, "R3 slave read");
        mread(2, 8'h00, "R4 status after read");
        cyc(); s_cs_n = 1; s_rd_n = 0;
        @(negedge clk);
        check("R3 oe unselected", int'(s_oe), 0);
        check("R3 bus unselected", int'(s_rdata), 0);
        // R5 and R7 inbound
        swrite(8'h3C, 0);
        mread(2, 8'h02, "R5 status");
        mread(1, 8'h3C, "R7 inbound");
        mread(2, 8'h00, "R7 status cleared");
        // R6 unselected write
        swrite(8'h55, 1);
        mread(2, 8'h00, "R6 status");
        mread(1, 8'h3C, "R6 inbound kept");
        // R9 overruns
        mwrite(0, 8'h11); mwrite(0, 8'h22);
        mread(2, 8'h05, "R9 out overrun");
        sread(8'h22, "R9 overwritten");
        mread(2, 8'h04, "R9 sticky");
        swrite(8'h66, 0); swrite(8'h77, 0);
        mread(2, 8'h0E, "R9 in overrun");
        mread(1, 8'h77, "R9 in overwritten");
        mread(2, 8'h0C, "R9 in sticky");
        // R10 clear
        mwrite(2, 8'h00);
        mread(2, 8'h00, "R10 cleared");
        // R11 reserved address and ignored writes
        mread(3, 8'h00, "R11 addr3");
        mwrite(1, 8'hFF); mwrite(3, 8'hFF);
        mread(2, 8'h00, "R11 status");
        mread(1, 8'h77, "R11 inbound kept");
        // R9 inbound collision: capture meets master take
        swrite(8'h12, 0);
        mread(2, 8'h02, "R9 pre-collision");
        cyc(); idle(); s_cs_n = 0; s_wr_n = 0; s_wdata = 8'h34;
        cyc(); s_wr_n = 1; m_rd_en = 1; m_addr = 2'd1;
        @(negedge clk); check("R9 in collision old", int'(m_rdata), 8'h12);
        cyc(); idle();
        mread(2, 8'h02, "R9 in collision status");
        mread(1, 8'h34, "R9 in collision data");
        // R9 outbound collision: master fill meets slave read start
        mwrite(0, 8'h56);
        cyc(); idle(); s_cs_n = 0; s_rd_n = 0;
        m_wr_en = 1; m_addr = 2'd0; m_wdata = 8'h78;
        @(negedge clk); check("R9 out collision old", int'(s_rdata), 8'h56);
        cyc(); idle();
        mread(2, 8'h01, "R9 out collision status");
        sread(8'h78, "R9 out collision data");
        // R10 set wins over clear
        swrite(8'h01, 0);
        cyc(); idle(); s_cs_n = 0; s_wr_n = 0; s_wdata = 8'h02;
        cyc(); s_wr_n = 1; m_wr_en = 1; m_addr = 2'd2;
        cyc(); idle();
        mread(2, 8'h0A, "R10 set wins");
        mwrite(2, 8'h00);
        mread(2, 8'h02, "R10 cleared again");
        cyc();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule